// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block takes one asynchronous non-maskable interrupt request from outside the chip and turns it into a level interrupt for a parent controller. The request pin is brought into the clock domain through a flop chain. It is then qualified by a programmable trigger condition: active-low level, active-high level, falling edge or rising edge. The qualified condition drives a single pending flag. The output to the parent is that flag gated by an enable bit.

Software reaches three 32-bit registers over a plain bus with address, write strobe, write data and combinational read data. The first register is control, which holds the trigger type. The second is pending, which reads the flag and is cleared by writing one to bit 0. The third is enable, which masks or unmasks the line through bit 0. Control always sits at offset 0x00. A build parameter chooses which of the other two registers sits at 0x04 and which at 0x08.

Top module: `nmi_line_ctl`

## Requirements
- R1: After reset every register reads 0 and irq_out is 0. The trigger type is therefore active-low level, the line is masked and nothing is pending. The synchronizer resets to the idle-high value, so an idle-high pin raises nothing.
- R2: A write to control stores all 32 bits, and a read returns the last value written. Bits [1:0] select the trigger.
- R3: With trigger 1 (falling edge), a high-to-low transition of the synchronized pin sets pending. Pending stays at 1 after the pin returns high.
- R4: With trigger 3 (rising edge), a low-to-high transition sets pending and a high-to-low transition does not.
- R5: With trigger 0 (active-low level) or trigger 2 (active-high level), pending follows the active level of the synchronized pin one cycle later. It drops when the level becomes inactive.
- R6: In an edge mode, writing pending with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged. Pending reads back on bit 0, and bits [31:1] read as 0.
- R7: In a level mode, a clear write made while the level is still active leaves pending at 1.
- R8: When an edge and a clear write land in the same cycle, the flag ends up at 1.
- R9: Pending is set even while the line is masked. irq_out equals pending AND enable bit 0.
- R10: Enable bit 0 = 1 unmasks the line and 0 masks it. Enable reads back bit 0, and bits [31:1] read as 0.
- R11: With ALT_LAYOUT = 0, pending is at 0x04 and enable is at 0x08. With ALT_LAYOUT = 1, enable is at 0x04 and pending is at 0x08. Control is at 0x00 in both layouts.
- R12: A pin change sampled at a clock edge shows up in pending after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| nmi_pin | input | 1 | Asynchronous interrupt request |
| irq_out | output | 1 | Interrupt to the parent controller |

## Verification
A pin change driven on a falling clock edge passes through two synchronizer flops and then the pending flop. It is therefore due after the third following rising edge. The bench samples once after the second rising edge, where the old value must still show, and once after the third. Register writes take effect on the rising edge that samples the strobe. Read data and irq_out are combinational from the registers, so each expectation is queued when its address is driven on a falling edge and compared one nanosecond later. The set-wins case times the clear strobe so that it is sampled on the same rising edge that latches the edge.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

   localparam int unsigned REG_W = 32;

   // Trigger encoding: bit 1 picks polarity (1 = high/rising), bit 0 picks edge sensing
   typedef enum logic [1:0] {
      TRIG_LVL_LO    = 2'd0,
      TRIG_EDGE_FALL = 2'd1,
      TRIG_LVL_HI    = 2'd2,
      TRIG_EDGE_RISE = 2'd3
   } trig_e;

   localparam int unsigned OFF_CTRL = 0;
   localparam int unsigned OFF_SLOT_A = 4;
   localparam int unsigned OFF_SLOT_B = 8;

   function automatic logic trig_is_edge(trig_e t);
      return t[0];
   endfunction

   function automatic logic trig_is_high(trig_e t);
      return t[1];
   endfunction

endpackage

// File: rtl/nmi_line_sync.sv
module nmi_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nmi_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_line_detect.sv
module nmi_line_detect
   import nmi_line_pkg::*;
#(
   parameter bit RST_VAL = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pin_s,
   input  trig_e trig,
   input  logic  clr,
   output logic  pend
);

   logic prev_q;
   logic pend_q;
   logic is_edge;
   logic active;
   logic hit_rise;
   logic hit_fall;
   logic edge_hit;
   logic pend_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_VAL;
      end else begin
         prev_q <= pin_s;
      end
   end

   always_comb begin
      is_edge  = trig_is_edge(trig);
      active   = trig_is_high(trig) ? pin_s : ~pin_s;
      hit_rise = pin_s & ~prev_q;
      hit_fall = ~pin_s & prev_q;
      edge_hit = trig_is_high(trig) ? hit_rise : hit_fall;
      if (is_edge) begin
         pend_nxt = edge_hit | (pend_q & ~clr);
      end else begin
         pend_nxt = active;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_nxt;
      end
   end

   assign pend = pend_q;

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge && pend_q && !clr) |=> pend_q); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge && edge_hit && clr) |=> pend_q); // R8

   AST_W1C_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge && clr && !edge_hit) |=> !pend_q); // R6

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_edge && active && clr) |=> pend_q); // R7

endmodule

// File: rtl/nmi_line_regs.sv
module nmi_line_regs
   import nmi_line_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter bit          ALT_LAYOUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              pend,
   output trig_e             trig,
   output logic              clr,
   output logic              en
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("nmi_line_regs: ADDR_W must reach offset 0x08");
      end
   endgenerate

   logic [ADDR_W-1:0] off_pend;
   logic [ADDR_W-1:0] off_en;

   generate
      if (ALT_LAYOUT) begin : g_layout_alt
         assign off_en   = ADDR_W'(OFF_SLOT_A);
         assign off_pend = ADDR_W'(OFF_SLOT_B);
      end else begin : g_layout_std
         assign off_pend = ADDR_W'(OFF_SLOT_A);
         assign off_en   = ADDR_W'(OFF_SLOT_B);
      end
   endgenerate

   logic sel_ctrl;
   logic sel_pend;
   logic sel_en;
   logic [REG_W-1:0] ctrl_q;
   logic en_q;

   assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
   assign sel_pend = (bus_addr == off_pend);
   assign sel_en   = (bus_addr == off_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= 1'b0;
      end else if (bus_wr) begin
         if (sel_ctrl) ctrl_q <= bus_wdata;
         if (sel_en)   en_q   <= bus_wdata[0];
      end
   end

   assign clr  = bus_wr & sel_pend & bus_wdata[0];
   assign trig = trig_e'(ctrl_q[1:0]);
   assign en   = en_q;

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl)      bus_rdata = ctrl_q;
      else if (sel_pend) bus_rdata[0] = pend;
      else if (sel_en)   bus_rdata[0] = en_q;
   end

   AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_ctrl) |=> (ctrl_q == $past(bus_wdata))); // R2

   AST_EN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_en && !bus_wdata[0]) |=> !en_q); // R10

endmodule

// File: rtl/nmi_line_ctl.sv
module nmi_line_ctl
   import nmi_line_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter bit          ALT_LAYOUT  = 1'b0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IDLE_VAL    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              nmi_pin,
   output logic              irq_out
);

   logic  pin_s;
   logic  pend;
   logic  clr;
   logic  en;
   trig_e trig;

   nmi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (nmi_pin),
      .dout (pin_s)
   );

   nmi_line_detect #(.RST_VAL(IDLE_VAL)) u_detect (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_s(pin_s),
      .trig (trig),
      .clr  (clr),
      .pend (pend)
   );

   nmi_line_regs #(.ADDR_W(ADDR_W), .ALT_LAYOUT(ALT_LAYOUT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pend     (pend),
      .trig     (trig),
      .clr      (clr),
      .en       (en)
   );

   assign irq_out = pend & en;

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !irq_out); // R9

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> pend); // R9

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_out); // R1

endmodule

// File: tb/nmi_line_ctl_test.sv
`timescale 1ns/1ps
module nmi_line_ctl_test;

   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0] addr = '0;
   logic          wr = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          pin = 1'b1;
   logic          irq;

   logic [AW-1:0] a_addr = '0;
   logic          a_wr = 1'b0;
   logic [31:0]   a_wdata = '0;
   logic [31:0]   a_rdata;
   logic          a_pin = 1'b1;
   logic          a_irq;

   nmi_line_ctl #(.ADDR_W(AW), .ALT_LAYOUT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
      .bus_wdata(wdata), .bus_rdata(rdata), .nmi_pin(pin), .irq_out(irq));

   nmi_line_ctl #(.ADDR_W(AW), .ALT_LAYOUT(1'b1)) uut_alt (
      .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr),
      .bus_wdata(a_wdata), .bus_rdata(a_rdata), .nmi_pin(a_pin), .irq_out(a_irq));

   typedef struct {
      int          kind;   // 0 rdata, 1 irq, 2 alt rdata, 3 alt irq
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Monitor: compares queued expectations 1 ns after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0: act = rdata;
               1: act = {31'b0, irq};
               2: act = a_rdata;
               default: act = {31'b0, a_irq};
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic wr_reg(bit alt, logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      if (alt) begin a_addr = a; a_wdata = d; a_wr = 1'b1; end
      else     begin addr = a;   wdata = d;   wr = 1'b1;   end
      @(negedge clk);
      a_wr = 1'b0;
      wr = 1'b0;
   endtask

   task automatic chk_rd(bit alt, logic [AW-1:0] a, logic [31:0] e, string tag);
      item_t it;
      @(negedge clk);
      if (alt) a_addr = a; else addr = a;
      it.kind = alt ? 2 : 0;
      it.exp = e;
      it.tag = tag;
      q.push_back(it);
      @(posedge clk);
   endtask

   task automatic chk_irq(bit alt, logic e, string tag);
      item_t it;
      @(negedge clk);
      it.kind = alt ? 3 : 1;
      it.exp = {31'b0, e};
      it.tag = tag;
      q.push_back(it);
      @(posedge clk);
   endtask

   task automatic set_pin(bit alt, logic v);
      @(negedge clk);
      if (alt) a_pin = v; else pin = v;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      cyc(3);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_rd(0, 4'h0, 32'h0, "R1");
      chk_rd(0, 4'h4, 32'h0, "R1");
      chk_rd(0, 4'h8, 32'h0, "R1");
      chk_irq(0, 1'b0, "R1");

      // R2 full control readback, falling-edge trigger
      wr_reg(0, 4'h0, 32'hA5A5_5A01);
      chk_rd(0, 4'h0, 32'hA5A5_5A01, "R2");

      // R12 latency, R3 falling edge
      set_pin(0, 1'b0);
      cyc(2);
      chk_rd(0, 4'h4, 32'h0, "R12");
      chk_rd(0, 4'h4, 32'h1, "R3");
      set_pin(0, 1'b1);
      cyc(4);
      chk_rd(0, 4'h4, 32'h1, "R3");
      chk_irq(0, 1'b0, "R9");

      // R10 enable
      wr_reg(0, 4'h8, 32'hFFFF_FFFF);
      chk_rd(0, 4'h8, 32'h1, "R10");
      chk_irq(0, 1'b1, "R9");
      wr_reg(0, 4'h8, 32'h0);
      chk_irq(0, 1'b0, "R10");
      chk_rd(0, 4'h4, 32'h1, "R9");
      wr_reg(0, 4'h8, 32'h1);

      // R6 write-one-to-clear
      wr_reg(0, 4'h4, 32'hFFFF_FFFE);
      chk_rd(0, 4'h4, 32'h1, "R6");
      wr_reg(0, 4'h4, 32'h1);
      chk_rd(0, 4'h4, 32'h0, "R6");
      chk_irq(0, 1'b0, "R6");

      // R4 rising edge
      wr_reg(0, 4'h0, 32'h3);
      set_pin(0, 1'b0);
      cyc(4);
      chk_rd(0, 4'h4, 32'h0, "R4");
      set_pin(0, 1'b1);
      cyc(4);
      chk_rd(0, 4'h4, 32'h1, "R4");
      wr_reg(0, 4'h4, 32'h1);
      chk_rd(0, 4'h4, 32'h0, "R6");

      // R8 edge and clear on the same rising edge
      set_pin(0, 1'b0);
      cyc(4);
      chk_rd(0, 4'h4, 32'h0, "R8");
      set_pin(0, 1'b1);
      @(negedge clk);
      wr_reg(0, 4'h4, 32'h1);
      chk_rd(0, 4'h4, 32'h1, "R8");
      wr_reg(0, 4'h4, 32'h1);
      chk_rd(0, 4'h4, 32'h0, "R8");

      // R5 level low, R7 clear ignored while active
      wr_reg(0, 4'h0, 32'h0);
      cyc(2);
      chk_rd(0, 4'h4, 32'h0, "R5");
      set_pin(0, 1'b0);
      cyc(4);
      chk_rd(0, 4'h4, 32'h1, "R5");
      chk_irq(0, 1'b1, "R5");
      wr_reg(0, 4'h4, 32'h1);
      chk_rd(0, 4'h4, 32'h1, "R7");
      set_pin(0, 1'b1);
      cyc(4);
      chk_rd(0, 4'h4, 32'h0, "R5");

      // R5 level high
      wr_reg(0, 4'h0, 32'h2);
      cyc(2);
      chk_rd(0, 4'h4, 32'h1, "R5");
      set_pin(0, 1'b0);
      cyc(4);
      chk_rd(0, 4'h4, 32'h0, "R5");

      // R11 alternate layout
      chk_rd(1, 4'h4, 32'h0, "R11");
      wr_reg(1, 4'h4, 32'h1);
      chk_rd(1, 4'h4, 32'h1, "R11");
      chk_rd(1, 4'h8, 32'h0, "R11");
      wr_reg(1, 4'h0, 32'h1);
      set_pin(1, 1'b0);
      cyc(4);
      chk_rd(1, 4'h8, 32'h1, "R11");
      chk_irq(1, 1'b1, "R11");
      wr_reg(1, 4'h4, 32'h1);
      chk_rd(1, 4'h8, 32'h1, "R11");
      wr_reg(1, 4'h8, 32'h1);
      chk_rd(1, 4'h8, 32'h0, "R11");
      chk_irq(1, 1'b0, "R11");

      cyc(3);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule